// File: doc/BRIEF.md
# Segmented Base-and-Bound Address Translator

This block converts each virtual address issued by a processor into a physical address. It holds one base register and one bound register for every segment of a process image, such as code, heap and stack. The top bits of the virtual address choose the segment. The remaining bits are an offset into that segment. The physical address is the offset added to the segment's base. An offset at or past the segment's bound is refused with an out-of-bounds fault.

The base/bound pairs are loaded through a configuration port. The supervisor reloads them on every context switch. A write is only accepted when the privileged-mode qualifier is high. A write made in user mode leaves the pair unchanged and is reported with its own cause code.

Both the translation result and the configuration result are registered. Each appears exactly one cycle after its strobe. The block only signals faults; trap handling is done elsewhere.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `xl_valid_o`, `xl_fault_o` and `cfg_done_o` are low. All four pairs hold base 0 and bound 0, so any translation before configuration faults with cause 1.
- R2: The segment is `xl_va_i[17:16]` and the offset is `xl_va_i[15:0]`. When the offset is below the bound, `xl_pa_o` equals base + offset modulo 2^20. For example, with base 32768, offset 128 gives 32896 and offset 1024 gives 33792.
- R3: When the offset is equal to or greater than the selected bound, `xl_fault_o` is 1, `xl_cause_o` is 1 (out of bounds) and `xl_pa_o` is 0. An offset of bound−1 translates without a fault. With bound 16384, offset 20480 faults.
- R4: A request on `xl_req_i` at one clock edge produces `xl_valid_o` high for exactly the following cycle, together with its result. With no request, `xl_valid_o` and `xl_fault_o` are low in the next cycle.
- R5: A configuration write with `cfg_priv_i` high stores base and bound into the selected slot. In the next cycle `cfg_done_o` is 1 and `cfg_cause_o` is 0.
- R6: A configuration write with `cfg_priv_i` low leaves every pair unchanged. In the next cycle `cfg_done_o` is 1 and `cfg_cause_o` is 2 (privilege violation).
- R7: The four pairs are independent. Writing one slot does not change how the other three slots translate.
- R8: A translation in the same cycle as a write to its own slot uses the pair held before that write.
- R9: Cause code 0 means no fault. A translation result never carries cause 2, and a configuration result never carries cause 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_priv_i | input | 1 | High when the writer is in privileged mode |
| cfg_seg_i | input | 2 | Slot to write |
| cfg_base_i | input | 20 | New base value |
| cfg_bound_i | input | 17 | New bound value (segment size) |
| cfg_done_o | output | 1 | Configuration result valid |
| cfg_cause_o | output | 2 | 0 = accepted, 2 = privilege violation |
| xl_req_i | input | 1 | Translation request strobe |
| xl_va_i | input | 18 | Virtual address, made of segment select and offset |
| xl_valid_o | output | 1 | Translation result valid |
| xl_pa_o | output | 20 | Physical address, 0 on fault |
| xl_fault_o | output | 1 | Translation faulted |
| xl_cause_o | output | 2 | 0 = none, 1 = out of bounds |

## Verification
The bench targets offsets exactly at the bound and one below it. A comparator written with the wrong sign would pass the first or fault the second. It also uses a bound of 0, which must fault for every offset, and base+offset sums that overflow 20 bits, where a widened or saturated adder would return the wrong address.

User-mode writes are followed by translations through the targeted slot. If the privilege gate were missing, the later translations would show the new base. Writes and requests are issued to the same slot in the same cycle. A design that forwarded the new pair would show the changed result one cycle too early.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_OOB  = 2'd1,
    CAUSE_PRIV = 2'd2
  } cause_e;
endpackage

// File: rtl/seg_regs.sv
module seg_regs #(
  parameter int SEG_W = 2,
  parameter int PA_W  = 20,
  parameter int BND_W = 17,
  localparam int NSEG = 1 << SEG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEG_W-1:0] wr_seg_i,
  input  logic [PA_W-1:0]  wr_base_i,
  input  logic [BND_W-1:0] wr_bound_i,
  input  logic [SEG_W-1:0] rd_seg_i,
  output logic [PA_W-1:0]  rd_base_o,
  output logic [BND_W-1:0] rd_bound_o
);
  logic [PA_W-1:0]  base_q  [NSEG];
  logic [BND_W-1:0] bound_q [NSEG];

  for (genvar s = 0; s < NSEG; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[s]  <= '0;
        bound_q[s] <= '0;
      end else if (wr_en_i && wr_seg_i == SEG_W'(s)) begin
        base_q[s]  <= wr_base_i;
        bound_q[s] <= wr_bound_i;
      end
    end
  end

  assign rd_base_o  = base_q[rd_seg_i];
  assign rd_bound_o = bound_q[rd_seg_i];
endmodule

// File: rtl/seg_calc.sv
module seg_calc #(
  parameter int OFF_W = 16,
  parameter int PA_W  = 20,
  localparam int BND_W = OFF_W + 1
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [BND_W-1:0] bound_i,
  output logic [PA_W-1:0]  pa_o,
  output logic             oob_o
);
  // wraps modulo 2^PA_W
  assign pa_o  = base_i + PA_W'(off_i);
  assign oob_o = {1'b0, off_i} >= bound_i;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int VA_W  = 18,
  parameter int SEG_W = 2,
  parameter int PA_W  = 20,
  localparam int OFF_W = VA_W - SEG_W,
  localparam int BND_W = OFF_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_priv_i,
  input  logic [SEG_W-1:0] cfg_seg_i,
  input  logic [PA_W-1:0]  cfg_base_i,
  input  logic [BND_W-1:0] cfg_bound_i,
  output logic             cfg_done_o,
  output logic [1:0]       cfg_cause_o,
  input  logic             xl_req_i,
  input  logic [VA_W-1:0]  xl_va_i,
  output logic             xl_valid_o,
  output logic [PA_W-1:0]  xl_pa_o,
  output logic             xl_fault_o,
  output logic [1:0]       xl_cause_o
);
  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] off;
  logic [PA_W-1:0]  sel_base, pa_d;
  logic [BND_W-1:0] sel_bound;
  logic             oob;
  logic             wr_ok;

  assign seg   = xl_va_i[VA_W-1 -: SEG_W];
  assign off   = xl_va_i[OFF_W-1:0];
  assign wr_ok = cfg_we_i & cfg_priv_i;

  seg_regs #(.SEG_W(SEG_W), .PA_W(PA_W), .BND_W(BND_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_ok),
    .wr_seg_i   (cfg_seg_i),
    .wr_base_i  (cfg_base_i),
    .wr_bound_i (cfg_bound_i),
    .rd_seg_i   (seg),
    .rd_base_o  (sel_base),
    .rd_bound_o (sel_bound)
  );

  seg_calc #(.OFF_W(OFF_W), .PA_W(PA_W)) u_calc (
    .off_i   (off),
    .base_i  (sel_base),
    .bound_i (sel_bound),
    .pa_o    (pa_d),
    .oob_o   (oob)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xl_valid_o  <= 1'b0;
      xl_pa_o     <= '0;
      xl_fault_o  <= 1'b0;
      xl_cause_o  <= CAUSE_NONE;
      cfg_done_o  <= 1'b0;
      cfg_cause_o <= CAUSE_NONE;
    end else begin
      xl_valid_o  <= xl_req_i;
      xl_fault_o  <= xl_req_i & oob;
      xl_pa_o     <= (xl_req_i && !oob) ? pa_d : '0;
      xl_cause_o  <= (xl_req_i && oob) ? CAUSE_OOB : CAUSE_NONE;
      cfg_done_o  <= cfg_we_i;
      cfg_cause_o <= (cfg_we_i && !cfg_priv_i) ? CAUSE_PRIV : CAUSE_NONE;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int PA_W = 20
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_we_i,
  input logic            cfg_priv_i,
  input logic            cfg_done_o,
  input logic [1:0]      cfg_cause_o,
  input logic            xl_req_i,
  input logic            xl_valid_o,
  input logic [PA_W-1:0] xl_pa_o,
  input logic            xl_fault_o,
  input logic [1:0]      xl_cause_o
);
  // R4
  req_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_req_i |=> xl_valid_o);
  // R4
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xl_req_i |=> (!xl_valid_o && !xl_fault_o));
  // R3
  fault_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_fault_o |-> (xl_valid_o && xl_cause_o == 2'd1 && xl_pa_o == '0));
  // R9
  xl_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_cause_o != 2'd2 && (xl_cause_o != 2'd0) == xl_fault_o);
  // R6
  user_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_priv_i) |=> (cfg_done_o && cfg_cause_o == 2'd2));
  // R5
  priv_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_priv_i) |=> (cfg_done_o && cfg_cause_o == 2'd0));
  // R9
  cfg_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_cause_o != 2'd1 && (!cfg_done_o -> cfg_cause_o == 2'd0));
endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_priv_i  (cfg_priv_i),
  .cfg_done_o  (cfg_done_o),
  .cfg_cause_o (cfg_cause_o),
  .xl_req_i    (xl_req_i),
  .xl_valid_o  (xl_valid_o),
  .xl_pa_o     (xl_pa_o),
  .xl_fault_o  (xl_fault_o),
  .xl_cause_o  (xl_cause_o)
);

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_priv_i = 1'b0;
  logic [1:0]  cfg_seg_i = '0;
  logic [19:0] cfg_base_i = '0;
  logic [16:0] cfg_bound_i = '0;
  logic        cfg_done_o;
  logic [1:0]  cfg_cause_o;
  logic        xl_req_i = 1'b0;
  logic [17:0] xl_va_i = '0;
  logic        xl_valid_o, xl_fault_o;
  logic [19:0] xl_pa_o;
  logic [1:0]  xl_cause_o;

  int tests = 0, fails = 0;
  logic [19:0] m_base [4];
  logic [16:0] m_bound[4];

  always #10 clk_i = ~clk_i;

  seg_xlate uut (.*);

  task automatic check(string tag, logic ok, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic is_oob(logic [17:0] va);
    return {1'b0, va[15:0]} >= m_bound[va[17:16]];
  endfunction

  function automatic logic [19:0] exp_pa(logic [17:0] va);
    return is_oob(va) ? 20'd0 : 20'(m_base[va[17:16]] + 20'(va[15:0]));
  endfunction

  // one cycle: drive at negedge, sample 1 ns after the next rising edge
  task automatic step(string tag, logic we, logic priv, logic [1:0] sg,
                      logic [19:0] b, logic [16:0] bd, logic rq, logic [17:0] va);
    logic e_oob;
    logic [19:0] e_pa;
    @(negedge clk_i);
    cfg_we_i = we; cfg_priv_i = priv; cfg_seg_i = sg;
    cfg_base_i = b; cfg_bound_i = bd; xl_req_i = rq; xl_va_i = va;
    e_oob = is_oob(va);
    e_pa  = exp_pa(va);
    @(posedge clk_i);
    #1;
    if (we && priv) begin m_base[sg] = b; m_bound[sg] = bd; end
    check({tag, " R4 valid"}, xl_valid_o == rq, 32'(xl_valid_o), 32'(rq));
    if (rq) begin
      check({tag, " R3 fault"}, xl_fault_o == e_oob, 32'(xl_fault_o), 32'(e_oob));
      check({tag, " R2 pa"}, xl_pa_o == e_pa, 32'(xl_pa_o), 32'(e_pa));
      check({tag, " R9 xl cause"}, xl_cause_o == {1'b0, e_oob},
            32'(xl_cause_o), 32'(e_oob));
    end else begin
      check({tag, " R4 idle fault"}, !xl_fault_o, 32'(xl_fault_o), 0);
    end
    check({tag, " R5 done"}, cfg_done_o == we, 32'(cfg_done_o), 32'(we));
    if (we)
      check({tag, " R6 cause"}, cfg_cause_o == (priv ? 2'd0 : 2'd2),
            32'(cfg_cause_o), priv ? 0 : 2);
  endtask

  task automatic rd(string tag, logic [17:0] va);
    step(tag, 1'b0, 1'b0, 2'd0, '0, '0, 1'b1, va);
  endtask

  task automatic wr(string tag, logic priv, logic [1:0] sg, logic [19:0] b, logic [16:0] bd);
    step(tag, 1'b1, priv, sg, b, bd, 1'b0, '0);
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin m_base[i] = '0; m_bound[i] = '0; end
    #25;
    check("R1 reset valid", !xl_valid_o && !xl_fault_o && !cfg_done_o, 32'(xl_valid_o), 0);
    rst_ni = 1'b1;
    // R1: all slots fault before configuration
    for (int s = 0; s < 4; s++) rd("R1 unconfigured", {2'(s), 16'd0});
    // R2/R3 worked example on slot 0
    wr("R5 cfg slot0", 1'b1, 2'd0, 20'd32768, 17'd16384);
    rd("R2 va128", {2'd0, 16'd128});
    check("R2 32896", xl_pa_o == 20'd32896, 32'(xl_pa_o), 32896);
    rd("R2 va1k", {2'd0, 16'd1024});
    check("R2 33792", xl_pa_o == 20'd33792, 32'(xl_pa_o), 33792);
    rd("R3 va20k", {2'd0, 16'd20480});
    check("R3 20k faults", xl_fault_o && xl_cause_o == 2'd1, 32'(xl_cause_o), 1);
    rd("R3 at bound", {2'd0, 16'd16384});
    rd("R3 bound-1", {2'd0, 16'd16383});
    check("R3 bound-1 ok", !xl_fault_o, 32'(xl_fault_o), 0);
    // R6: user write rejected, slot0 unchanged
    wr("R6 user wr", 1'b0, 2'd0, 20'd5, 17'd65536);
    rd("R6 after user wr", {2'd0, 16'd128});
    check("R6 pa kept", xl_pa_o == 20'd32896, 32'(xl_pa_o), 32896);
    // R7: write slot1, others unaffected
    wr("R7 cfg slot1", 1'b1, 2'd1, 20'hFFF00, 17'd65536);
    rd("R7 slot0", {2'd0, 16'd128});
    rd("R7 slot2", {2'd2, 16'd0});
    rd("R2 wrap", {2'd1, 16'h0200});
    check("R2 wrap value", xl_pa_o == 20'h00100, 32'(xl_pa_o), 32'h100);
    rd("R3 full bound", {2'd1, 16'hFFFF});
    // R8: same-cycle write and read on slot0 sees old pair
    step("R8 same cycle", 1'b1, 1'b1, 2'd0, 20'd100, 17'd10, 1'b1, {2'd0, 16'd128});
    check("R8 old pair", xl_pa_o == 20'd32896, 32'(xl_pa_o), 32896);
    rd("R8 new pair", {2'd0, 16'd128});
    // R3: bound 0 faults
    wr("R3 zero bound", 1'b1, 2'd3, 20'd7, 17'd0);
    rd("R3 zero bound rd", {2'd3, 16'd0});
    // random mix
    for (int i = 0; i < 800; i++) begin
      logic [1:0]  sg = 2'($urandom);
      logic [17:0] va = 18'($urandom);
      logic [16:0] bd = 17'($urandom_range(0, 65536));
      if ($urandom_range(0, 3) == 0)
        va[15:0] = 16'(m_bound[va[17:16]] - 17'($urandom_range(0, 1)));
      step("R7 random", $urandom_range(0, 4) == 0, 1'($urandom), sg,
           20'($urandom), bd, 1'($urandom), va);
    end
    step("R4 idle", 1'b0, 1'b0, 2'd0, '0, '0, 1'b0, '0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule